// File: doc/BRIEF.md
# Multiprocessor Address Recognizer for a Serial Receiver

This block sits behind the bit-level receiver of a serial port running in multiprocessor mode. Every received frame carries an eight-bit byte and a ninth bit. A ninth bit of one marks an address frame. For an address frame, the block decides whether this node is being addressed. For a data frame, it decides whether the frame belongs to a node that is currently selected. It raises a one-cycle acceptance pulse, together with the frame contents, which the receiver uses to set its receive flag.

Two programmable registers drive the decision: a node address and an enable mask. The recognizer builds two patterns from them.

- The individual pattern compares only the byte bits where the mask holds a one. Those bits must equal the node address.
- The broadcast pattern is the bitwise OR of address and mask. Every one in it must be a one in the received byte, and zeros are free.

Because each node ignores different bits, one address byte can select several nodes at once. When both registers are zero, every bit of both patterns is free. Address recognition is then off and the block accepts every frame.

Top module: `mp_addr_match`

## Requirements
- R1: After reset, the address register and the mask register are zero, `hit_o` and `selected_o` are low, and `hit_byte_o` is zero. While both registers are zero, every frame is accepted, whatever its ninth bit.
- R2: A cycle with `cfg_we` high loads `cfg_wdata` into one register: the address register when `cfg_sel` is 0, the mask register when `cfg_sel` is 1. With `cfg_we` low, the registers keep their values. A frame that arrives in the same cycle as a write is judged against the values from before the write.
- R3: An address frame matches the individual pattern when, for every bit where the mask is 1, the received bit equals the address bit. Bits where the mask is 0 are ignored. Example: with address 0xE0 and mask 0xFA, byte 0xE5 is accepted and byte 0xE6 is rejected.
- R4: An address frame matches the broadcast pattern when every bit that is 1 in (address OR mask) is also 1 in the received byte. Example: with address 0xE0 and mask 0xFA, bytes 0xFF and 0xFA are accepted.
- R5: An address frame (ninth bit 1) is accepted when it matches the individual pattern or the broadcast pattern.
- R6: Each address frame sets `selected_o` to its own acceptance result. While either register is non-zero, a data frame (ninth bit 0) is accepted only when `selected_o` is high, and it leaves `selected_o` unchanged.
- R7: On the clock edge that samples `rx_valid` high, the block makes its acceptance decision. It raises `hit_o` for exactly the following cycle. In that cycle `hit_byte_o` and `hit_is_addr_o` carry the frame's byte and ninth bit, and they hold those values until the next accepted frame.
- R8: While `rx_valid` is low, `rx_byte` and `rx_ninth` have no effect: `hit_o` stays low and `hit_byte_o` and `selected_o` hold.
- R9: With address 0xC0 and mask 0xF9 (individual pattern 1100_0XX0), address byte 0xC6 is accepted and 0xC1 is rejected.
- R10: With address 0xE0 and the masks 0xF9, 0xFA and 0xFC in turn, address byte 0xE4 is accepted under the first two masks and rejected under the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 address, 1 mask |
| cfg_wdata | input | 8 | Register write data |
| rx_valid | input | 1 | A received frame is present this cycle |
| rx_byte | input | 8 | Received data byte |
| rx_ninth | input | 1 | Received ninth bit, 1 for an address frame |
| hit_o | output | 1 | One-cycle acceptance pulse |
| hit_byte_o | output | 8 | Byte of the last accepted frame |
| hit_is_addr_o | output | 1 | Ninth bit of the last accepted frame |
| selected_o | output | 1 | This node is selected by the last address frame |

## Verification
The bench builds the block with its default byte width of eight. At that width the register values used in the worked examples can be written directly, including the three-node selection with one shared byte.

The bench keeps a behavioural model that walks the bits one at a time. It compares the model with every output on every clock. As a result, the bench checks every combination of the individual and broadcast patterns, data frames arriving before and after a selection, disabled recognition, and a write that collides with a frame.

// File: rtl/mpa_pkg.sv
// Package: shared types and constants for the multiprocessor address recognizer.
// Assumes: register select is a single bit; byte width defaults to eight.
package mpa_pkg;

    localparam int unsigned DEF_BYTE_W = 8;

    // Register select encoding on the configuration port.
    typedef enum logic {
        CFG_ADDR = 1'b0,
        CFG_MASK = 1'b1
    } cfg_sel_e;

    // Comparison flavour chosen by a comparator instance.
    typedef enum int unsigned {
        CMP_INDIVIDUAL = 0,
        CMP_BROADCAST  = 1
    } cmp_kind_e;

    // Per-frame match results from both comparators.
    typedef struct packed {
        logic individual;
        logic broadcast;
    } match_t;

endpackage

// File: rtl/mpa_cfg_regs.sv
// Module: holds the node address and enable mask registers.
// Assumes: synchronous active-low reset clears both; one write per cycle.
module mpa_cfg_regs
    import mpa_pkg::*;
#(
    parameter int unsigned BYTE_W = DEF_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              sel,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] addr_q,
    output logic [BYTE_W-1:0] mask_q
);

    logic addr_wr;
    logic mask_wr;

    // Decode the write strobe onto one of the two registers.
    always_comb begin
        addr_wr = we && (cfg_sel_e'(sel) == CFG_ADDR);
        mask_wr = we && (cfg_sel_e'(sel) == CFG_MASK);
    end

    // Address register storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       addr_q <= '0;
        else if (addr_wr) addr_q <= wdata;
    end

    // Mask register storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= wdata;
    end

endmodule

// File: rtl/mpa_masked_cmp.sv
// Module: per-bit masked comparison of a received byte against a pattern.
// KIND selects the individual pattern (mask bits are the care bits, address
// bits are the reference) or the broadcast pattern (OR of address and mask
// gives the care bits, the reference is all ones). Purely combinational.
module mpa_masked_cmp
    import mpa_pkg::*;
#(
    parameter int unsigned BYTE_W = DEF_BYTE_W,
    parameter cmp_kind_e   KIND   = CMP_INDIVIDUAL
) (
    input  logic [BYTE_W-1:0] addr,
    input  logic [BYTE_W-1:0] mask,
    input  logic [BYTE_W-1:0] rx,
    output logic              hit
);

    logic [BYTE_W-1:0] care;
    logic [BYTE_W-1:0] refv;
    logic [BYTE_W-1:0] bit_ok;

    // Build the care bits and the reference value for the chosen flavour.
    generate
        if (KIND == CMP_INDIVIDUAL) begin : g_indiv
            assign care = mask;
            assign refv = addr;
        end else begin : g_bcast
            assign care = addr | mask;
            assign refv = {BYTE_W{1'b1}};
        end
    endgenerate

    // One cell per bit: satisfied when the bit is free or equal to the reference.
    generate
        for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
            assign bit_ok[i] = !care[i] || (rx[i] == refv[i]);
        end
    endgenerate

    // A hit needs every bit cell satisfied.
    always_comb hit = &bit_ok;

endmodule

// File: rtl/mpa_accept.sv
// Module: turns match results into the acceptance pulse and selection state.
// Assumes: inputs are valid in the cycle rx_valid is high; outputs registered.
module mpa_accept
    import mpa_pkg::*;
#(
    parameter int unsigned BYTE_W = DEF_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_ninth,
    input  logic [BYTE_W-1:0] rx_byte,
    input  match_t            match,
    input  logic              recog_on,
    output logic              hit,
    output logic [BYTE_W-1:0] hit_byte,
    output logic              hit_is_addr,
    output logic              selected
);

    logic addr_match;
    logic accept_now;

    // Decide acceptance for the frame present this cycle.
    always_comb begin
        addr_match = match.individual || match.broadcast;
        if (!rx_valid)     accept_now = 1'b0;
        else if (rx_ninth) accept_now = addr_match;
        else               accept_now = !recog_on || selected;
    end

    // One-cycle pulse for an accepted frame.
    always_ff @(posedge clk) begin
        if (!rst_n) hit <= 1'b0;
        else        hit <= accept_now;
    end

    // Capture the contents of each accepted frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_byte    <= '0;
            hit_is_addr <= 1'b0;
        end else if (accept_now) begin
            hit_byte    <= rx_byte;
            hit_is_addr <= rx_ninth;
        end
    end

    // Each address frame replaces the selection with its own result.
    always_ff @(posedge clk) begin
        if (!rst_n)                     selected <= 1'b0;
        else if (rx_valid && rx_ninth)  selected <= addr_match;
    end

endmodule

// File: rtl/mp_addr_match.sv
// Module: top of the multiprocessor address recognizer.
// Combines the register file, the individual and broadcast comparators and the
// acceptance stage. Assumes one frame at most per cycle from the receiver.
module mp_addr_match
    import mpa_pkg::*;
#(
    parameter int unsigned BYTE_W = DEF_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [BYTE_W-1:0] cfg_wdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_ninth,
    output logic              hit_o,
    output logic [BYTE_W-1:0] hit_byte_o,
    output logic              hit_is_addr_o,
    output logic              selected_o
);

    logic [BYTE_W-1:0] cfg_addr;
    logic [BYTE_W-1:0] cfg_mask;
    match_t            match;
    logic              recog_on;

    mpa_cfg_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .sel    (cfg_sel),
        .wdata  (cfg_wdata),
        .addr_q (cfg_addr),
        .mask_q (cfg_mask)
    );

    mpa_masked_cmp #(.BYTE_W(BYTE_W), .KIND(CMP_INDIVIDUAL)) u_indiv (
        .addr (cfg_addr),
        .mask (cfg_mask),
        .rx   (rx_byte),
        .hit  (match.individual)
    );

    mpa_masked_cmp #(.BYTE_W(BYTE_W), .KIND(CMP_BROADCAST)) u_bcast (
        .addr (cfg_addr),
        .mask (cfg_mask),
        .rx   (rx_byte),
        .hit  (match.broadcast)
    );

    // Recognition is active once either register holds a one.
    always_comb recog_on = |{cfg_addr, cfg_mask};

    mpa_accept #(.BYTE_W(BYTE_W)) u_accept (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_valid    (rx_valid),
        .rx_ninth    (rx_ninth),
        .rx_byte     (rx_byte),
        .match       (match),
        .recog_on    (recog_on),
        .hit         (hit_o),
        .hit_byte    (hit_byte_o),
        .hit_is_addr (hit_is_addr_o),
        .selected    (selected_o)
    );

endmodule

// File: rtl/mp_addr_match_chk.sv
// Module: property checker bound to mp_addr_match.
module mp_addr_match_chk #(
    parameter int unsigned BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              rx_ninth,
    input logic [BYTE_W-1:0] rx_byte,
    input logic [BYTE_W-1:0] addr_q,
    input logic [BYTE_W-1:0] mask_q,
    input logic              hit_o,
    input logic [BYTE_W-1:0] hit_byte_o,
    input logic              hit_is_addr_o,
    input logic              selected_o
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!hit_o && !selected_o && addr_q == '0 && mask_q == '0));

    // R3
    individual_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ninth && (((rx_byte ^ addr_q) & mask_q) == '0)) |=> hit_o);

    // R4
    broadcast_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ninth && ((~rx_byte & (addr_q | mask_q)) == '0)) |=> hit_o);

    // R6
    data_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ninth && !selected_o && ((addr_q | mask_q) != '0)) |=> !hit_o);

    // R6
    addr_hit_selects_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && hit_is_addr_o) |-> selected_o);

    // R7
    hit_carries_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && $past(rst_n)) |=> (!hit_o || (hit_byte_o == $past(rx_byte) && hit_is_addr_o == $past(rx_ninth))));

    // R8
    idle_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> (!hit_o && $stable(hit_byte_o) && $stable(selected_o)));

endmodule

bind mp_addr_match mp_addr_match_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_valid      (rx_valid),
    .rx_ninth      (rx_ninth),
    .rx_byte       (rx_byte),
    .addr_q        (cfg_addr),
    .mask_q        (cfg_mask),
    .hit_o         (hit_o),
    .hit_byte_o    (hit_byte_o),
    .hit_is_addr_o (hit_is_addr_o),
    .selected_o    (selected_o)
);

// File: tb/sim_mp_addr_match.sv
// Bench: directed frames plus a per-clock behavioural reference model.
module sim_mp_addr_match;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_sel = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_ninth = 1'b0;
    logic       hit_o;
    logic [7:0] hit_byte_o;
    logic       hit_is_addr_o;
    logic       selected_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    mp_addr_match u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_sel       (cfg_sel),
        .cfg_wdata     (cfg_wdata),
        .rx_valid      (rx_valid),
        .rx_byte       (rx_byte),
        .rx_ninth      (rx_ninth),
        .hit_o         (hit_o),
        .hit_byte_o    (hit_byte_o),
        .hit_is_addr_o (hit_is_addr_o),
        .selected_o    (selected_o)
    );

    // Reference model state.
    logic [7:0] m_addr, m_mask, e_byte;
    logic       m_sel, e_hit, e_isaddr;
    bit         started = 0;

    function automatic bit indiv_ok(input logic [7:0] a, input logic [7:0] m, input logic [7:0] b);
        for (int i = 0; i < 8; i++)
            if (m[i] && (b[i] != a[i])) return 0;
        return 1;
    endfunction

    function automatic bit bcast_ok(input logic [7:0] a, input logic [7:0] m, input logic [7:0] b);
        for (int i = 0; i < 8; i++)
            if ((a[i] || m[i]) && !b[i]) return 0;
        return 1;
    endfunction

    always @(posedge clk) begin
        bit match, take;
        started = 1;
        if (!rst_n) begin
            m_addr = 0; m_mask = 0; m_sel = 0;
            e_hit = 0; e_byte = 0; e_isaddr = 0;
        end else begin
            match = indiv_ok(m_addr, m_mask, rx_byte) || bcast_ok(m_addr, m_mask, rx_byte);
            if (!rx_valid)     take = 0;
            else if (rx_ninth) take = match;
            else               take = (m_addr == 0 && m_mask == 0) || m_sel;
            e_hit = take;
            if (take) begin e_byte = rx_byte; e_isaddr = rx_ninth; end
            if (rx_valid && rx_ninth) m_sel = match;
            if (cfg_we) begin
                if (cfg_sel) m_mask = cfg_wdata;
                else         m_addr = cfg_wdata;
            end
        end
    end

    // Compare every output with the model, away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            checks++;
            if (hit_o !== e_hit || hit_byte_o !== e_byte ||
                hit_is_addr_o !== e_isaddr || selected_o !== m_sel) begin
                fails++;
                $display("FAIL R7 model: got hit=%b byte=%h addr=%b sel=%b exp hit=%b byte=%h addr=%b sel=%b",
                         hit_o, hit_byte_o, hit_is_addr_o, selected_o, e_hit, e_byte, e_isaddr, m_sel);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic frame(input logic [7:0] b, input logic n, input logic exp, input string req);
        @(negedge clk);
        rx_valid = 1; rx_byte = b; rx_ninth = n;
        @(negedge clk);
        rx_valid = 0;
        chk(req, {31'b0, hit_o}, {31'b0, exp});
        if (exp) chk(req, {23'b0, hit_is_addr_o, hit_byte_o}, {23'b0, n, b});
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R1", {hit_o, selected_o, hit_byte_o}, 32'h0);
        rst_n = 1;
        // R1: recognition off, every frame taken
        frame(8'h5A, 1, 1, "R1");
        frame(8'h33, 0, 1, "R1");
        // R3/R4/R5/R6 with address E0 mask FA
        wr(0, 8'hE0); wr(1, 8'hFA);
        frame(8'hE5, 1, 1, "R3");
        chk("R6", {31'b0, selected_o}, 1);
        frame(8'h11, 0, 1, "R6");
        frame(8'hE6, 1, 0, "R3");
        chk("R6", {31'b0, selected_o}, 0);
        frame(8'h22, 0, 0, "R6");
        frame(8'hFF, 1, 1, "R4");
        frame(8'hFA, 1, 1, "R5");
        // R8: inputs toggling without rx_valid
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            rx_byte = 8'h40 + k[7:0]; rx_ninth = k[0];
            chk("R8", {22'b0, hit_o, selected_o, hit_byte_o}, {22'b0, 1'b0, 1'b1, 8'hFA});
        end
        // R2: strobe low does nothing
        @(negedge clk); cfg_we = 0; cfg_sel = 0; cfg_wdata = 8'h00;
        frame(8'hE6, 1, 0, "R2");
        // R2: write coinciding with a frame uses the old values
        @(negedge clk);
        cfg_we = 1; cfg_sel = 1; cfg_wdata = 8'h00;
        rx_valid = 1; rx_byte = 8'hE6; rx_ninth = 1;
        @(negedge clk);
        cfg_we = 0; rx_valid = 0;
        chk("R2", {31'b0, hit_o}, 0);
        frame(8'hE6, 1, 1, "R2");
        // R9
        wr(0, 8'hC0); wr(1, 8'hF9);
        frame(8'hC6, 1, 1, "R9");
        frame(8'hC1, 1, 0, "R9");
        // R10: three nodes, one byte
        wr(0, 8'hE0); wr(1, 8'hF9);
        frame(8'hE4, 1, 1, "R10");
        wr(1, 8'hFA);
        frame(8'hE4, 1, 1, "R10");
        wr(1, 8'hFC);
        frame(8'hE4, 1, 0, "R10");
        frame(8'h77, 0, 0, "R6");
        // R1: reset mid-run restores open acceptance
        @(negedge clk); rst_n = 0;
        @(negedge clk);
        chk("R1", {hit_o, selected_o, hit_byte_o}, 32'h0);
        rst_n = 1;
        frame(8'h01, 1, 1, "R1");
        frame(8'h02, 0, 1, "R1");
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule